// File: doc/BRIEF.md
# Stack-Aware Instruction Execute Unit

This block executes one already decoded instruction at a time. It takes an opcode, a function code, two register identifiers, a 32-bit immediate and the fall-through PC. It works against an internal file of eight 32-bit registers, three condition flags (zero, sign, overflow) and one word-wide data memory port. For each instruction it reports a status and, when the instruction completes normally, the next PC.

The instruction set covers register and immediate moves, base-plus-offset loads and stores, four ALU operations, an immediate add, conditional jumps and conditional moves. It also covers five stack operations: call, return, push, pop and leave. These operations work on register 4, the stack pointer, implicitly. Leave also uses register 5, the frame pointer. The stack step is one word (4 bytes).

An accepted instruction spends one busy cycle, in which the memory access is made, and then raises `done` for one cycle. The memory port must answer combinationally in the same cycle: `mem_rdata` and `mem_err` are functions of the address and request presented that cycle. A write is performed at the clock edge that ends the cycle, and only when no error is reported.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset, all registers and flags are zero, `next_pc` is 0, `status` is 0, and `busy` and `done` are low. As a result, an equal-condition jump after reset is not taken.
- R2: Handshake timing.
  - `start` while idle is accepted. `busy` is high for exactly the next cycle, and `done` is high for the cycle after that.
  - `start` while busy is ignored.
- R3: Store (opcode 4) writes rA to address imm + rB, and load (opcode 5) reads that address into rA. A memory error on the access gives status 2.
- R4: ALU op (opcode 6) writes the result to rB and updates the flags. Function 0 is rB+rA, 1 is rB−rA, 2 is AND and 3 is XOR. Overflow is set only for add and subtract.
- R5: Conditions by function code:
  - 0 always
  - 1 less-or-equal
  - 2 less
  - 3 equal
  - 4 not-equal
  - 5 greater-or-equal
  - 6 greater

  Jump (opcode 7) sets `next_pc` to imm when the condition holds, and to the fall-through PC otherwise. Conditional move (opcode 2) copies rA to rB only when its condition holds.
- R6: Call (opcode 8) lowers the stack pointer by 4, stores the fall-through PC at the new stack pointer, and sets `next_pc` to imm.
- R7: Return (opcode 9) reads the word at the stack pointer, raises the stack pointer by 4, and sets `next_pc` to the word read.
- R8: Push (opcode 10) lowers the stack pointer by 4 and stores rA there. Pop (opcode 11) reads the word at the old stack pointer, raises the stack pointer by 4, and writes the word to rA. When rA is the stack pointer, the loaded word wins.
- R9: Leave (opcode 13) sets the stack pointer to frame pointer + 4 and loads the frame pointer from the old frame pointer address.
- R10: Status 3 is reported in each of these cases:
  - a used register field is 8 or more
  - an undefined opcode
  - an ALU function above 3
  - a condition code above 6

  In each case no memory request is issued.
- R11: Immediate add (opcode 12) writes rB + imm to rB and sets the flags as an addition.
- R12: Halt (opcode 0) reports status 1 and leaves `next_pc` unchanged.
- R13: On status 1, 2 or 3, no register, flag, memory or `next_pc` update takes effect.
- R14: Register move from immediate (opcode 3) writes imm to rB. Nop (opcode 1) changes nothing. A normal completion reports status 0 with `next_pc` equal to the fall-through PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Offer an instruction |
| op_code | input | 4 | Opcode |
| op_fn | input | 4 | Function / condition code |
| op_ra | input | 4 | First register identifier |
| op_rb | input | 4 | Second register identifier |
| op_imm | input | 32 | Immediate word |
| op_ftpc | input | 32 | Fall-through PC |
| busy | output | 1 | Instruction in execution |
| done | output | 1 | Result valid this cycle |
| status | output | 2 | 0 ok, 1 halt, 2 address error, 3 invalid |
| next_pc | output | 32 | PC after the last completed instruction |
| mem_req | output | 1 | Data memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, same cycle |
| mem_err | input | 1 | Access failed, same cycle |

## Verification
The checker watches the timing rules on every cycle:
- the busy-then-done sequence and the single-cycle `done` pulse
- memory requests only while busy, with writes only as part of a request
- `next_pc` holding whenever halt or an error is reported

The arithmetic, the flag-driven condition choices, and the order of pointer update against memory access in each stack operation can only be shown by the bench's instruction scenarios. The bench observes the register contents they leave behind by storing registers to its memory model.

// File: rtl/exu_pkg.sv
// Shared encodings for the execute unit: opcodes, ALU functions,
// status codes and the flag word. Assumes 4-bit opcode/function fields.
package exu_pkg;
    localparam logic [3:0] OP_HALT  = 4'h0;
    localparam logic [3:0] OP_NOP   = 4'h1;
    localparam logic [3:0] OP_CMOV  = 4'h2;
    localparam logic [3:0] OP_IRMOV = 4'h3;
    localparam logic [3:0] OP_STORE = 4'h4;
    localparam logic [3:0] OP_LOAD  = 4'h5;
    localparam logic [3:0] OP_ALU   = 4'h6;
    localparam logic [3:0] OP_JUMP  = 4'h7;
    localparam logic [3:0] OP_CALL  = 4'h8;
    localparam logic [3:0] OP_RET   = 4'h9;
    localparam logic [3:0] OP_PUSH  = 4'hA;
    localparam logic [3:0] OP_POP   = 4'hB;
    localparam logic [3:0] OP_IADD  = 4'hC;
    localparam logic [3:0] OP_LEAVE = 4'hD;

    localparam logic [3:0] FN_ADD = 4'h0;
    localparam logic [3:0] FN_SUB = 4'h1;
    localparam logic [3:0] FN_AND = 4'h2;
    localparam logic [3:0] FN_XOR = 4'h3;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_HALT  = 2'd1,
        ST_ADDR  = 2'd2,
        ST_INVAL = 2'd3
    } status_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;
endpackage

// File: rtl/exu_alu.sv
// Integer ALU: add, subtract (b - a), and, xor, with zero/sign/overflow.
// Assumes two's-complement operands of W bits; fn_ok flags an unknown code.
module exu_alu
    import exu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output flags_t       flags,
    output logic         fn_ok
);
    logic ovf;

    // Result and overflow per function code.
    always_comb begin
        fn_ok = 1'b1;
        ovf   = 1'b0;
        res   = '0;
        case (fn)
            FN_ADD: begin
                res = b + a;
                ovf = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
            end
            FN_SUB: begin
                res = b - a;
                ovf = (a[W-1] != b[W-1]) && (res[W-1] != b[W-1]);
            end
            FN_AND: res = a & b;
            FN_XOR: res = a ^ b;
            default: fn_ok = 1'b0;
        endcase
    end

    // Flag word derived from the result.
    always_comb begin
        flags.zf = (res == '0);
        flags.sf = res[W-1];
        flags.of = ovf;
    end
endmodule

// File: rtl/exu_cond.sv
// Condition evaluator shared by conditional jump and conditional move.
// Assumes codes 0..6; anything above is reported through fn_ok.
module exu_cond
    import exu_pkg::*;
(
    input  flags_t     flags,
    input  logic [3:0] fn,
    output logic       take,
    output logic       fn_ok
);
    logic lt;

    // Signed-less-than from sign and overflow, then select by code.
    always_comb begin
        lt    = flags.sf ^ flags.of;
        fn_ok = 1'b1;
        case (fn)
            4'd0: take = 1'b1;
            4'd1: take = lt | flags.zf;
            4'd2: take = lt;
            4'd3: take = flags.zf;
            4'd4: take = ~flags.zf;
            4'd5: take = ~lt;
            4'd6: take = ~lt & ~flags.zf;
            default: begin
                take  = 1'b0;
                fn_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/exu_regfile.sv
// Register file with two write ports and all entries visible in parallel.
// Port M (memory result) wins over port E (computed value) on the same entry.
module exu_regfile #(
    parameter int W = 32,
    parameter int N = 8,
    localparam int AW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_e,
    input  logic [AW-1:0]       dst_e,
    input  logic [W-1:0]        val_e,
    input  logic                we_m,
    input  logic [AW-1:0]       dst_m,
    input  logic [W-1:0]        val_m,
    output logic [N-1:0][W-1:0] regs
);
    for (genvar i = 0; i < N; i++) begin : g_entry
        // One entry: clear on reset, memory write takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we_m && dst_m == AW'(i))
                regs[i] <= val_m;
            else if (we_e && dst_e == AW'(i))
                regs[i] <= val_e;
        end
    end
endmodule

// File: rtl/stack_exec_unit.sv
// Execute unit for one decoded instruction at a time.
// Assumes a data memory that answers rdata/err combinationally in the
// cycle of the request and writes at the clock edge ending it when no error.
// Accept -> one busy cycle (access + commit at its end) -> done pulse.
module stack_exec_unit
    import exu_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int ID_W     = 4,
    parameter int SP_REG   = 4,
    parameter int FP_REG   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op_code,
    input  logic [3:0]        op_fn,
    input  logic [ID_W-1:0]   op_ra,
    input  logic [ID_W-1:0]   op_rb,
    input  logic [DATA_W-1:0] op_imm,
    input  logic [DATA_W-1:0] op_ftpc,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [DATA_W-1:0] next_pc,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err
);
    localparam int AW = $clog2(NUM_REGS);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);
    localparam logic [AW-1:0] SP_IDX = AW'(SP_REG);
    localparam logic [AW-1:0] FP_IDX = AW'(FP_REG);

    typedef enum logic {S_IDLE, S_EXEC} state_e;
    state_e state_q;

    logic [3:0]        q_op, q_fn;
    logic [ID_W-1:0]   q_ra, q_rb;
    logic [DATA_W-1:0] q_imm, q_ft;

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    flags_t flags_q;

    logic              done_q;
    status_e           status_q;
    logic [DATA_W-1:0] pc_q;

    logic              ra_ok, rb_ok, exec;
    logic [AW-1:0]     ra_idx, rb_idx;
    logic [DATA_W-1:0] rav, rbv, spv, fpv;

    logic              bad, is_halt, req_c, we_c, set_cc_c;
    logic              we_e_c, we_m_c;
    logic [AW-1:0]     dst_e_c, dst_m_c;
    logic [DATA_W-1:0] val_e_c, addr_c, wdata_c, pc_c;
    status_e           st_c;
    logic              commit;

    logic [3:0]        alu_fn;
    logic [DATA_W-1:0] alu_a, alu_res;
    flags_t            alu_flags;
    logic              alu_fn_ok, cond_take, cond_fn_ok;

    // Control state: one accepted instruction spends exactly one EXEC cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else if (state_q == S_IDLE && start)
            state_q <= S_EXEC;
        else
            state_q <= S_IDLE;
    end

    // Capture the offered instruction on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_op <= OP_NOP; q_fn <= '0; q_ra <= '0; q_rb <= '0;
            q_imm <= '0; q_ft <= '0;
        end else if (state_q == S_IDLE && start) begin
            q_op <= op_code; q_fn <= op_fn; q_ra <= op_ra; q_rb <= op_rb;
            q_imm <= op_imm; q_ft <= op_ftpc;
        end
    end

    assign exec   = (state_q == S_EXEC);
    assign ra_ok  = (q_ra < ID_W'(NUM_REGS));
    assign rb_ok  = (q_rb < ID_W'(NUM_REGS));
    assign ra_idx = q_ra[AW-1:0];
    assign rb_idx = q_rb[AW-1:0];
    assign rav    = regs[ra_idx];
    assign rbv    = regs[rb_idx];
    assign spv    = regs[SP_IDX];
    assign fpv    = regs[FP_IDX];

    exu_alu #(.W(DATA_W)) u_alu (
        .fn(alu_fn), .a(alu_a), .b(rbv),
        .res(alu_res), .flags(alu_flags), .fn_ok(alu_fn_ok)
    );

    exu_cond u_cond (
        .flags(flags_q), .fn(q_fn), .take(cond_take), .fn_ok(cond_fn_ok)
    );

    // Per-opcode decode of validity, memory access, writebacks and next PC.
    always_comb begin
        bad = 1'b0; is_halt = 1'b0; req_c = 1'b0; we_c = 1'b0;
        addr_c = '0; wdata_c = '0; set_cc_c = 1'b0;
        we_e_c = 1'b0; dst_e_c = '0; val_e_c = '0;
        we_m_c = 1'b0; dst_m_c = '0;
        pc_c = q_ft; alu_a = rav; alu_fn = q_fn;
        case (q_op)
            OP_HALT: is_halt = 1'b1;
            OP_NOP:  ;
            OP_CMOV: begin
                bad = !ra_ok || !rb_ok || !cond_fn_ok;
                we_e_c = cond_take; dst_e_c = rb_idx; val_e_c = rav;
            end
            OP_IRMOV: begin
                bad = !rb_ok;
                we_e_c = 1'b1; dst_e_c = rb_idx; val_e_c = q_imm;
            end
            OP_STORE: begin
                bad = !ra_ok || !rb_ok;
                req_c = 1'b1; we_c = 1'b1; addr_c = q_imm + rbv; wdata_c = rav;
            end
            OP_LOAD: begin
                bad = !ra_ok || !rb_ok;
                req_c = 1'b1; addr_c = q_imm + rbv;
                we_m_c = 1'b1; dst_m_c = ra_idx;
            end
            OP_ALU: begin
                bad = !ra_ok || !rb_ok || !alu_fn_ok;
                we_e_c = 1'b1; dst_e_c = rb_idx; val_e_c = alu_res;
                set_cc_c = 1'b1;
            end
            OP_JUMP: begin
                bad = !cond_fn_ok;
                pc_c = cond_take ? q_imm : q_ft;
            end
            OP_CALL: begin
                req_c = 1'b1; we_c = 1'b1; addr_c = spv - STEP; wdata_c = q_ft;
                we_e_c = 1'b1; dst_e_c = SP_IDX; val_e_c = spv - STEP;
                pc_c = q_imm;
            end
            OP_RET: begin
                req_c = 1'b1; addr_c = spv;
                we_e_c = 1'b1; dst_e_c = SP_IDX; val_e_c = spv + STEP;
                pc_c = mem_rdata;
            end
            OP_PUSH: begin
                bad = !ra_ok;
                req_c = 1'b1; we_c = 1'b1; addr_c = spv - STEP; wdata_c = rav;
                we_e_c = 1'b1; dst_e_c = SP_IDX; val_e_c = spv - STEP;
            end
            OP_POP: begin
                bad = !ra_ok;
                req_c = 1'b1; addr_c = spv;
                we_e_c = 1'b1; dst_e_c = SP_IDX; val_e_c = spv + STEP;
                we_m_c = 1'b1; dst_m_c = ra_idx;
            end
            OP_IADD: begin
                bad = !rb_ok;
                alu_a = q_imm; alu_fn = FN_ADD;
                we_e_c = 1'b1; dst_e_c = rb_idx; val_e_c = alu_res;
                set_cc_c = 1'b1;
            end
            OP_LEAVE: begin
                req_c = 1'b1; addr_c = fpv;
                we_e_c = 1'b1; dst_e_c = SP_IDX; val_e_c = fpv + STEP;
                we_m_c = 1'b1; dst_m_c = FP_IDX;
            end
            default: bad = 1'b1;
        endcase
    end

    // Status priority: invalid, then halt, then memory fault.
    always_comb begin
        if (bad)                  st_c = ST_INVAL;
        else if (is_halt)         st_c = ST_HALT;
        else if (req_c && mem_err) st_c = ST_ADDR;
        else                      st_c = ST_OK;
    end

    assign commit    = exec && (st_c == ST_OK);
    assign mem_req   = exec && req_c && !bad;
    assign mem_we    = mem_req && we_c;
    assign mem_addr  = addr_c;
    assign mem_wdata = wdata_c;

    exu_regfile #(.W(DATA_W), .N(NUM_REGS)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we_e(commit && we_e_c), .dst_e(dst_e_c), .val_e(val_e_c),
        .we_m(commit && we_m_c), .dst_m(dst_m_c), .val_m(mem_rdata),
        .regs(regs)
    );

    // Condition flags: updated only by committed ALU / immediate-add.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (commit && set_cc_c)
            flags_q <= alu_flags;
    end

    // Result registers: done pulse, status of last instruction, next PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            status_q <= ST_OK;
            pc_q     <= '0;
        end else begin
            done_q <= exec;
            if (exec) status_q <= st_c;
            if (commit) pc_q <= pc_c;
        end
    end

    assign busy    = exec;
    assign done    = done_q;
    assign status  = status_q;
    assign next_pc = pc_q;
endmodule

// File: rtl/stack_exec_unit_chk.sv
// Timing and no-commit properties for stack_exec_unit, bound to every instance.
module stack_exec_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [1:0]        status,
    input logic [DATA_W-1:0] next_pc,
    input logic              mem_req,
    input logic              mem_we
);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R2
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done && !busy));
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    req_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    // R3
    we_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);
    // R12
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd1) |-> $stable(next_pc));
    // R13
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[1]) |-> $stable(next_pc));
endmodule

bind stack_exec_unit stack_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .status(status), .next_pc(next_pc), .mem_req(mem_req), .mem_we(mem_we)
);

// File: tb/stack_exec_unit_tb.sv
module stack_exec_unit_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  req;
        logic [3:0]  op, fn, ra, rb;
        logic [31:0] imm, ft;
        logic [1:0]  st;
        logic [31:0] pc;
    } vec_t;

    // Instruction program: req, op, fn, ra, rb, imm, ft, exp status, exp pc
    // (status != 0 means next_pc must stay at its previous value).
    localparam int NV = 53;
    localparam vec_t VEC [0:NV-1] = '{
        {8'd14, 4'h3,4'h0,4'hF,4'h4, 32'h0F0, 32'h010, 2'd0, 32'h010}, // R14 sp
        {8'd14, 4'h3,4'h0,4'hF,4'h1, 32'h004, 32'h020, 2'd0, 32'h020},
        {8'd14, 4'h3,4'h0,4'hF,4'h2, 32'h007, 32'h030, 2'd0, 32'h030},
        {8'd4,  4'h6,4'h0,4'h1,4'h2, 32'h000, 32'h040, 2'd0, 32'h040}, // R4 r2=11
        {8'd3,  4'h4,4'h0,4'h2,4'h1, 32'h01C, 32'h050, 2'd0, 32'h050}, // R3 store
        {8'd3,  4'h5,4'h0,4'h3,4'h1, 32'h01C, 32'h060, 2'd0, 32'h060}, // R3 load
        {8'd4,  4'h6,4'h1,4'h3,4'h2, 32'h000, 32'h070, 2'd0, 32'h070}, // R4 sub Z
        {8'd5,  4'h7,4'h3,4'h0,4'h0, 32'h200, 32'h080, 2'd0, 32'h200}, // R5 je
        {8'd5,  4'h7,4'h4,4'h0,4'h0, 32'h300, 32'h090, 2'd0, 32'h090}, // R5 jne
        {8'd5,  4'h2,4'h3,4'h1,4'h6, 32'h000, 32'h0A0, 2'd0, 32'h0A0}, // R5 cmove
        {8'd5,  4'h2,4'h4,4'h1,4'h7, 32'h000, 32'h0B0, 2'd0, 32'h0B0}, // R5 cmovne
        {8'd5,  4'h4,4'h0,4'h7,4'h0, 32'h048, 32'h0C0, 2'd0, 32'h0C0},
        {8'd5,  4'h4,4'h0,4'h6,4'h0, 32'h044, 32'h0D0, 2'd0, 32'h0D0},
        {8'd8,  4'hA,4'h0,4'h6,4'hF, 32'h000, 32'h0E0, 2'd0, 32'h0E0}, // R8 push
        {8'd6,  4'h8,4'h0,4'hF,4'hF, 32'h400, 32'h055, 2'd0, 32'h400}, // R6 call
        {8'd7,  4'h9,4'h0,4'hF,4'hF, 32'h000, 32'h999, 2'd0, 32'h055}, // R7 ret
        {8'd8,  4'hB,4'h0,4'h7,4'hF, 32'h000, 32'h0F0, 2'd0, 32'h0F0}, // R8 pop
        {8'd8,  4'h4,4'h0,4'h7,4'h0, 32'h040, 32'h100, 2'd0, 32'h100},
        {8'd14, 4'h3,4'h0,4'hF,4'h5, 32'h060, 32'h110, 2'd0, 32'h110},
        {8'd9,  4'hD,4'h0,4'hF,4'hF, 32'h000, 32'h120, 2'd0, 32'h120}, // R9 leave
        {8'd9,  4'h4,4'h0,4'h4,4'h0, 32'h04C, 32'h130, 2'd0, 32'h130},
        {8'd9,  4'h4,4'h0,4'h5,4'h0, 32'h050, 32'h140, 2'd0, 32'h140},
        {8'd11, 4'hC,4'h0,4'hF,4'h1, 32'hFFFFFFFC, 32'h150, 2'd0, 32'h150}, // R11
        {8'd11, 4'h7,4'h3,4'h0,4'h0, 32'h500, 32'h160, 2'd0, 32'h500},
        {8'd14, 4'h3,4'h0,4'hF,4'h1, 32'h7FFFFFFF, 32'h170, 2'd0, 32'h170},
        {8'd14, 4'h3,4'h0,4'hF,4'h2, 32'h001, 32'h180, 2'd0, 32'h180},
        {8'd4,  4'h6,4'h0,4'h2,4'h1, 32'h000, 32'h190, 2'd0, 32'h190}, // R4 ovf
        {8'd5,  4'h7,4'h2,4'h0,4'h0, 32'h600, 32'h1A0, 2'd0, 32'h1A0}, // R5 jl
        {8'd5,  4'h7,4'h1,4'h0,4'h0, 32'h600, 32'h1B0, 2'd0, 32'h1B0}, // R5 jle
        {8'd5,  4'h7,4'h5,4'h0,4'h0, 32'h610, 32'h1C0, 2'd0, 32'h610}, // R5 jge
        {8'd5,  4'h7,4'h6,4'h0,4'h0, 32'h620, 32'h1D0, 2'd0, 32'h620}, // R5 jg
        {8'd14, 4'h3,4'h0,4'hF,4'h3, 32'hF0F0, 32'h1E0, 2'd0, 32'h1E0},
        {8'd14, 4'h3,4'h0,4'hF,4'h6, 32'h0FF0, 32'h1F0, 2'd0, 32'h1F0},
        {8'd4,  4'h6,4'h2,4'h3,4'h6, 32'h000, 32'h200, 2'd0, 32'h200}, // R4 and
        {8'd4,  4'h6,4'h3,4'h3,4'h3, 32'h000, 32'h210, 2'd0, 32'h210}, // R4 xor
        {8'd4,  4'h7,4'h3,4'h0,4'h0, 32'h700, 32'h220, 2'd0, 32'h700},
        {8'd4,  4'h4,4'h0,4'h6,4'h0, 32'h054, 32'h230, 2'd0, 32'h230},
        {8'd3,  4'h4,4'h0,4'h1,4'h0, 32'h1000, 32'h240, 2'd2, 32'h0},  // R3 fault
        {8'd10, 4'h3,4'h0,4'hF,4'h8, 32'h000, 32'h250, 2'd3, 32'h0},   // R10
        {8'd10, 4'hA,4'h0,4'h9,4'hF, 32'h000, 32'h260, 2'd3, 32'h0},
        {8'd10, 4'hE,4'h0,4'h0,4'h0, 32'h000, 32'h270, 2'd3, 32'h0},
        {8'd10, 4'h6,4'h5,4'h1,4'h2, 32'h000, 32'h280, 2'd3, 32'h0},
        {8'd10, 4'h7,4'h7,4'h0,4'h0, 32'h000, 32'h290, 2'd3, 32'h0},
        {8'd14, 4'h3,4'h0,4'hF,4'h4, 32'h400, 32'h2A0, 2'd0, 32'h2A0},
        {8'd13, 4'h9,4'h0,4'hF,4'hF, 32'h000, 32'h2B0, 2'd2, 32'h0},   // R13
        {8'd13, 4'h4,4'h0,4'h4,4'h0, 32'h05C, 32'h2C0, 2'd0, 32'h2C0},
        {8'd12, 4'h0,4'h0,4'h0,4'h0, 32'h000, 32'h2D0, 2'd1, 32'h0},   // R12
        {8'd14, 4'h3,4'h0,4'hF,4'h4, 32'h070, 32'h2E0, 2'd0, 32'h2E0},
        {8'd8,  4'hB,4'h0,4'h4,4'hF, 32'h000, 32'h2F0, 2'd0, 32'h2F0}, // R8 pop sp
        {8'd8,  4'h4,4'h0,4'h4,4'h0, 32'h058, 32'h300, 2'd0, 32'h300},
        {8'd13, 4'h5,4'h0,4'h1,4'h0, 32'h002, 32'h310, 2'd2, 32'h0},
        {8'd13, 4'h4,4'h0,4'h1,4'h0, 32'h064, 32'h320, 2'd0, 32'h320},
        {8'd10, 4'h2,4'h8,4'h1,4'h2, 32'h000, 32'h330, 2'd3, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_code = '0, op_fn = '0, op_ra = '0, op_rb = '0;
    logic [31:0] op_imm = '0, op_ftpc = '0;
    logic        busy, done, mem_req, mem_we, mem_err;
    logic [1:0]  status;
    logic [31:0] next_pc, mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:63];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .op_fn(op_fn), .op_ra(op_ra), .op_rb(op_rb), .op_imm(op_imm),
        .op_ftpc(op_ftpc), .busy(busy), .done(done), .status(status),
        .next_pc(next_pc), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_err(mem_err)
    );

    // Memory model: 256 bytes, word aligned, faults otherwise.
    assign mem_err   = (|mem_addr[31:8]) || (|mem_addr[1:0]);
    assign mem_rdata = mem_err ? 32'h0 : mem[mem_addr[7:2]];
    always @(posedge clk)
        if (mem_req && mem_we && !mem_err) mem[mem_addr[7:2]] <= mem_wdata;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [3:0] fn,
                         input logic [3:0] ra, input logic [3:0] rb,
                         input logic [31:0] imm, input logic [31:0] ft,
                         output logic seen, output logic [1:0] st,
                         output logic [31:0] pc);
        @(negedge clk);
        op_code = op; op_fn = fn; op_ra = ra; op_rb = rb;
        op_imm = imm; op_ftpc = ft; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        seen = done; st = status; pc = next_pc;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic        seen;
        logic [1:0]  st;
        logic [31:0] pc, last_pc;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        mem[18] = 32'hDEAD;
        mem[24] = 32'hABC0;
        mem[26] = 32'h5555;
        mem[28] = 32'h33;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 next_pc", next_pc, 32'h0);
        check("R1 status/busy/done", {30'h0, busy, done} | {30'h0, status}, 32'h0);
        rst_n = 1'b1;

        // R2 busy then done timing
        @(negedge clk);
        op_code = 4'h1; op_ftpc = 32'h8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy", {31'h0, busy}, 32'h1);
        check("R2 no early done", {31'h0, done}, 32'h0);
        @(negedge clk);
        check("R2 done", {31'h0, done}, 32'h1);
        check("R14 nop pc", next_pc, 32'h8);

        last_pc = 32'h8;
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].fn, VEC[i].ra, VEC[i].rb,
                  VEC[i].imm, VEC[i].ft, seen, st, pc);
            checks++;
            if (!seen || st !== VEC[i].st ||
                pc !== ((VEC[i].st == 2'd0) ? VEC[i].pc : last_pc)) begin
                errors++;
                $display("FAIL R%0d step %0d actual=%b/%0d/%h expected=1/%0d/%h",
                         VEC[i].req, i, seen, st, pc, VEC[i].st,
                         (VEC[i].st == 2'd0) ? VEC[i].pc : last_pc);
            end
            if (VEC[i].st == 2'd0) last_pc = VEC[i].pc;
        end

        // Memory contents left by the program
        check("R3 store",       mem[8],  32'd11);
        check("R8 pop value",   mem[16], 32'd4);
        check("R5 cmove taken", mem[17], 32'd4);
        check("R5 cmovne skip", mem[18], 32'h0);
        check("R9 leave sp",    mem[19], 32'h64);
        check("R9 leave fp",    mem[20], 32'hABC0);
        check("R4 and result",  mem[21], 32'hF0);
        check("R8 pop into sp", mem[22], 32'h33);
        check("R13 sp kept",    mem[23], 32'h400);
        check("R13 reg kept",   mem[25], 32'h80000000);
        check("R6 return addr", mem[58], 32'h55);
        check("R8 push value",  mem[59], 32'd4);

        // R2 start while busy is ignored
        @(negedge clk);
        op_code = 4'h3; op_fn = 4'h0; op_ra = 4'hF; op_rb = 4'h1;
        op_imm = 32'h11; op_ftpc = 32'h340; start = 1'b1;
        @(negedge clk);
        op_code = 4'h0; op_ftpc = 32'h999;
        @(negedge clk);
        start = 1'b0;
        check("R2 status after ignore", {30'h0, status}, 32'h0);
        check("R2 pc after ignore", next_pc, 32'h340);
        @(negedge clk);
        check("R2 no second instr", {30'h0, busy, done}, 32'h0);

        // R1 reset again mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 pc after reset", next_pc, 32'h0);
        rst_n = 1'b1;
        issue(4'h4, 4'h0, 4'h1, 4'h0, 32'h68, 32'h350, seen, st, pc);
        check("R1 regs cleared", mem[26], 32'h0);
        issue(4'h7, 4'h3, 4'h0, 4'h0, 32'h800, 32'h360, seen, st, pc);
        check("R1 flags cleared", pc, 32'h360);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule